// File: doc/BRIEF.md
# LIN Break Field Generator

This block drives the opening part of a LIN frame header on a serial transmit line: a long low level (the break) followed by a short high level (the break delimiter). Software sets both widths through an 8-bit configuration register. The register can be written only while the controller's reset-mode input is high. One bit time (Tbit) is a whole number of system clocks, set by a 16-bit divisor input.

A one-clock transmit request starts a sequence when the block is idle. At that point the block captures the two widths and the divisor. It then holds the line low for the break and high for the delimiter. In the final clock of the delimiter it raises a one-clock done pulse. The sync byte and all later fields are produced elsewhere. Those later stages follow the done pulse.

Top module: `lin_brk_gen`

## Requirements
- R1: After reset the configuration reads 0x00, the transmit line is high, and busy and done are low.
- R2: The break holds the line low for (configuration bits 3..0 + 13) Tbits. Code 0 gives 13 Tbits and code 15 gives 28 Tbits.
- R3: The delimiter holds the line high, with busy still high, for (configuration bits 5..4 + 1) Tbits. Code 0 gives 1 Tbit and code 3 gives 4 Tbits.
- R4: Configuration bits 7 and 6 always read 0, and values written to them have no effect.
- R5: A configuration write changes the register only when reset mode is high at the same clock edge. Writes at any other time leave the readback unchanged.
- R6: One Tbit lasts max(divisor, 1) system clocks. The divisor is captured when the sequence starts.
- R7: A transmit request while busy is high is ignored. This includes a request in the done cycle. Such a request neither lengthens the sequence nor starts a new one.
- R8: The widths are captured at the start edge. A configuration write during a sequence, or in the same cycle as the start, affects only later sequences.
- R9: Busy is high for exactly the break plus the delimiter, starting one clock after the request. Done is high for exactly one clock, the last clock of the delimiter. After the sequence the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| resetMode | input | 1 | High while the LIN controller is in reset mode; enables configuration writes |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write value |
| cfgRdData | output | 8 | Current configuration value |
| divisor | input | 16 | System clocks per Tbit (0 treated as 1) |
| txStart | input | 1 | Request to send a break sequence |
| txLine | output | 1 | Serial transmit line, idles high |
| busy | output | 1 | High during break and delimiter |
| done | output | 1 | One-clock pulse in the last delimiter clock |

## Verification
Two pairs of functions can land in the same clock edge.

The first pair is a new transmit request and the done pulse that ends the current sequence. The bench raises the request in the exact cycle where it observes done. It then expects busy to be low on the following clock, with no second sequence started.

The second pair is a configuration write in reset mode and a start request. The bench issues both in one cycle, and also writes again in the middle of a sequence. It measures the break and delimiter in clocks and requires them to match the old setting. The readback must show the new value, and the next sequence must use it.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BREAK = 2'd1,
    ST_DELIM = 2'd2
  } brkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture widths and divisor, clear counters
    logic run;        // advance prescaler and bit counter
    logic phaseHigh;  // select delimiter width for end-of-phase compare
    logic phaseEnd;   // current phase finishes this clock
  } brkStrobes_t;
endpackage

// File: rtl/lin_brk_dp.sv
module lin_brk_dp
  import lin_brk_pkg::*;
#(
  parameter int CFG_W     = 8,
  parameter int DIV_W     = 16,
  parameter int LOW_FW    = 4,
  parameter int HIGH_FW   = 2,
  parameter int LOW_BASE  = 13,
  parameter int HIGH_BASE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetMode,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic [DIV_W-1:0] divisor,
  input  brkStrobes_t      strb,
  output logic             bitTick,
  output logic             lastBit
);
  localparam int USED_W = LOW_FW + HIGH_FW;
  localparam int CNT_W  = $clog2(LOW_BASE + (1 << LOW_FW) + 1);

  logic [CFG_W-1:0] cfgReg;
  logic [CNT_W-1:0] lowWidth, highWidth, curWidth;
  logic [DIV_W-1:0] divLatched, presc, divEff;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgWrEn && resetMode) begin
      cfgReg <= {{(CFG_W-USED_W){1'b0}}, cfgWrData[USED_W-1:0]};
    end
  end

  assign cfgRdData = cfgReg;
  assign divEff    = (divisor == '0) ? DIV_W'(1) : divisor;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowWidth   <= '0;
      highWidth  <= '0;
      divLatched <= DIV_W'(1);
    end else if (strb.load) begin
      lowWidth   <= CNT_W'(cfgReg[LOW_FW-1:0]) + CNT_W'(LOW_BASE);
      highWidth  <= CNT_W'(cfgReg[USED_W-1:LOW_FW]) + CNT_W'(HIGH_BASE);
      divLatched <= divEff;
    end
  end

  assign bitTick  = strb.run && (presc == divLatched - DIV_W'(1));
  assign curWidth = strb.phaseHigh ? highWidth : lowWidth;
  assign lastBit  = bitTick && (bitCnt == curWidth - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc  <= '0;
      bitCnt <= '0;
    end else if (strb.load) begin
      presc  <= '0;
      bitCnt <= '0;
    end else if (strb.run) begin
      if (bitTick) begin
        presc  <= '0;
        bitCnt <= strb.phaseEnd ? '0 : bitCnt + CNT_W'(1);
      end else begin
        presc <= presc + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/lin_brk_ctrl.sv
module lin_brk_ctrl
  import lin_brk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txStart,
  input  logic        bitTick,
  input  logic        lastBit,
  output brkStrobes_t strb,
  output logic        txLine,
  output logic        busy,
  output logic        done
);
  brkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (txStart) stateNext = ST_BREAK;
      ST_BREAK: if (lastBit) stateNext = ST_DELIM;
      ST_DELIM: if (lastBit) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.load      = (state == ST_IDLE) && txStart;
    strb.run       = (state != ST_IDLE);
    strb.phaseHigh = (state == ST_DELIM);
    strb.phaseEnd  = lastBit;
  end

  assign txLine = (state != ST_BREAK);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DELIM) && lastBit && bitTick;
endmodule

// File: rtl/lin_brk_gen.sv
module lin_brk_gen
  import lin_brk_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetMode,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic [DIV_W-1:0] divisor,
  input  logic             txStart,
  output logic             txLine,
  output logic             busy,
  output logic             done
);
  brkStrobes_t strb;
  logic bitTick, lastBit;

  lin_brk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txStart(txStart),
    .bitTick(bitTick), .lastBit(lastBit), .strb(strb),
    .txLine(txLine), .busy(busy), .done(done)
  );

  lin_brk_dp #(.CFG_W(CFG_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .resetMode(resetMode),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .divisor(divisor), .strb(strb), .bitTick(bitTick), .lastBit(lastBit)
  );
endmodule

// File: rtl/lin_brk_chk.sv
module lin_brk_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             resetMode,
  input logic             txStart,
  input logic [CFG_W-1:0] cfgRdData,
  input logic             txLine,
  input logic             busy,
  input logic             done
);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && txLine));
  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);
  assert_end_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[CFG_W-1:CFG_W-2] == 2'b00);
  assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    !resetMode |=> $stable(cfgRdData));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && txStart) |=> busy);
  assert_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && txStart) |=> (busy && !txLine));
endmodule

bind lin_brk_gen lin_brk_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rstN(rstN), .resetMode(resetMode), .txStart(txStart),
  .cfgRdData(cfgRdData), .txLine(txLine), .busy(busy), .done(done)
);

// File: tb/sim_lin_brk_gen.sv
module sim_lin_brk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetMode = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic [15:0] divisor = 16'd1;
  logic        txStart = 1'b0;
  logic        txLine, busy, done;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit finished = 0;

  lin_brk_gen u0 (
    .clk(clk), .rstN(rstN), .resetMode(resetMode), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .divisor(divisor),
    .txStart(txStart), .txLine(txLine), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish();
    end
  end

  task automatic writeCfg(input logic [7:0] val, input logic mode);
    @(negedge clk);
    resetMode = mode; cfgWrEn = 1'b1; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0; resetMode = 1'b0;
  endtask

  // Run one sequence; optional start while busy, write mid-sequence or at start.
  task automatic runSeq(input logic [7:0] cfg, input int div, input bit pokeBusy,
                        input bit writeMid, input bit writeAtStart,
                        input logic [7:0] newCfg);
    int dEff, expLow, expHigh, lowCnt, highCnt, doneCnt, donePos, busyCnt;
    bit seenHigh, badOrder;
    dEff    = (div == 0) ? 1 : div;
    expLow  = (int'(cfg[3:0]) + 13) * dEff;
    expHigh = (int'(cfg[5:4]) + 1) * dEff;
    lowCnt = 0; highCnt = 0; doneCnt = 0; donePos = -1; busyCnt = 0;
    seenHigh = 0; badOrder = 0;
    @(negedge clk);
    divisor = 16'(div);
    txStart = 1'b1;
    if (writeAtStart) begin
      resetMode = 1'b1; cfgWrEn = 1'b1; cfgWrData = newCfg;
    end
    @(negedge clk);
    txStart = 1'b0; cfgWrEn = 1'b0; resetMode = 1'b0;
    divisor = 16'd7; // changing divisor mid-sequence must not matter (R6)
    while (busy && busyCnt < 2000) begin
      busyCnt++;
      if (!txLine) begin
        lowCnt++;
        if (seenHigh) badOrder = 1;
      end else begin
        highCnt++;
        seenHigh = 1;
      end
      if (done) begin
        doneCnt++;
        donePos = busyCnt;
      end
      if (pokeBusy && (busyCnt == 3 || done)) txStart = 1'b1;
      if (writeMid && busyCnt == 2) begin
        resetMode = 1'b1; cfgWrEn = 1'b1; cfgWrData = newCfg;
      end
      @(negedge clk);
      txStart = 1'b0; cfgWrEn = 1'b0; resetMode = 1'b0;
    end
    check("R2 break clocks", lowCnt, expLow);
    check("R3 delimiter clocks", highCnt, expHigh);
    check("R9 single done", doneCnt, 1);
    check("R9 done in last clock", donePos, expLow + expHigh);
    check("R2 low before high", int'(badOrder), 0);
    check("R9 line high after", int'(txLine), 1);
    @(negedge clk);
    check("R7 no restart", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cfg reset", int'(cfgRdData), 0);
    check("R1 line reset", int'(txLine), 1);
    check("R1 busy reset", int'(busy), 0);
    check("R1 done reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 default: 13-bit break, 1-bit delimiter
    runSeq(8'h00, 1, 0, 0, 0, 8'h00);

    // R2 / R3: sweep every code
    for (int c = 0; c < 64; c++) begin
      writeCfg(8'(c), 1'b1);
      check("R2 R3 readback", int'(cfgRdData), c);
      runSeq(8'(c), 1, 0, 0, 0, 8'h00);
    end

    // R4: reserved bits
    for (int v = 0; v < 4; v++) begin
      writeCfg({2'(v), 6'h2A}, 1'b1);
      check("R4 reserved read zero", int'(cfgRdData), 8'h2A);
    end
    runSeq(8'h2A, 1, 0, 0, 0, 8'h00);

    // R5: writes outside reset mode ignored
    writeCfg(8'h15, 1'b1);
    for (int v = 0; v < 4; v++) begin
      writeCfg(8'(8'h3F - v), 1'b0);
      check("R5 write ignored", int'(cfgRdData), 8'h15);
    end
    runSeq(8'h15, 2, 0, 0, 0, 8'h00);

    // R6: divisor sweep, including 0 treated as 1
    for (int d = 0; d < 5; d++) begin
      writeCfg(8'(16 * (d % 4) + 3 * d), 1'b1);
      runSeq(8'(16 * (d % 4) + 3 * d), d, 0, 0, 0, 8'h00);
    end

    // R7: start while busy and in the done cycle
    writeCfg(8'h31, 1'b1);
    runSeq(8'h31, 2, 1, 0, 0, 8'h00);
    runSeq(8'h31, 1, 1, 0, 0, 8'h00);

    // R8: write during a sequence and at the start edge
    writeCfg(8'h00, 1'b1);
    runSeq(8'h00, 1, 0, 1, 0, 8'h3F);
    check("R8 new value visible", int'(cfgRdData), 8'h3F);
    runSeq(8'h3F, 1, 0, 0, 1, 8'h05);
    check("R8 start-edge write visible", int'(cfgRdData), 8'h05);
    runSeq(8'h05, 3, 0, 0, 0, 8'h00);

    finished = 1;
    finish();
  end
endmodule